// File: doc/BRIEF.md
# Four-Phase Cross-Clock Request Handshake

This block carries one request at a time from a sender clock domain to a receiver clock domain. The two clocks are unrelated. A client in the sender domain pulses a start request with a data word. The sender controller registers the word, raises a command line and keeps the word unchanged until the exchange is over. A receiver controller in the other domain answers with an acknowledge line. In the cycle after it first sees the command, it emits a one-cycle action strobe together with the captured word.

The exchange is fully interlocked. The command rises, then the acknowledge rises, then the command falls, then the acknowledge falls. Each line passes through a two-flop synchronizer before it reaches a state decision in the other domain. As a result, every request produces exactly one action, whichever clock is faster. The data bus is not synchronized bit by bit. It is safe to sample because it stays stable for the whole exchange.

Top module: `xclk_handshake`

## Requirements
- R1: While either reset is held high (each reset is synchronous to its own clock), the block returns to idle with busy, done, actionStrobe, command and acknowledge all low.
- R2: A startReq sampled high while idle is accepted, and busy is high from the next sender cycle onward.
- R3: A startReq sampled while busy is high is ignored. It neither changes the word being delivered nor causes a further action.
- R4: The accepted word stays unchanged inside the block until the exchange completes, and actionData equals that word while actionStrobe is high.
- R5: actionStrobe is high for exactly one receiver cycle per accepted request, for a receiver clock faster than, similar to, or much slower than the sender clock.
- R6: The sender holds the command high until it sees the synchronized acknowledge high. The receiver holds the acknowledge high until it sees the synchronized command low.
- R7: done is high for exactly one sender cycle, in the cycle where busy falls, once the sender has seen the synchronized acknowledge low.
- R8: done appears no earlier than the 4th sender clock edge after the accepting edge. actionStrobe appears no earlier than the 3rd receiver clock edge after the accepting edge.
- R9: Each control line crosses through a chain of SYNC_STAGES flip-flops clocked by the destination clock, with a default of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sClk | input | 1 | Sender domain clock |
| sRst | input | 1 | Sender domain synchronous reset, active high |
| startReq | input | 1 | Request to start a transfer, sampled on sClk |
| startData | input | DATA_W | Word to deliver, sampled with startReq |
| busy | output | 1 | Transfer in progress in the sender domain |
| done | output | 1 | One-cycle completion pulse in the sender domain |
| rClk | input | 1 | Receiver domain clock |
| rRst | input | 1 | Receiver domain synchronous reset, active high |
| actionStrobe | output | 1 | One-cycle action pulse in the receiver domain |
| actionData | output | DATA_W | Word delivered with actionStrobe |

## Verification
Some properties are checked by assertions in every cycle. These cover the interlock on both sides: the command holds until the acknowledge is seen, and the acknowledge holds until the command is seen low. They also cover the single-cycle shape of done and actionStrobe, the acknowledge being high whenever the strobe fires, and the stability of the held word while busy. Other behaviours only the directed scenarios can show. These are exactly one action per request under three receiver-to-sender clock ratios, the correct word arriving, the discarding of a start issued mid-transfer, and the minimum latency set by the synchronizer chains.

// File: rtl/xclk_hs_pkg.sv
package xclk_hs_pkg;
  typedef enum logic [1:0] {
    SND_IDLE    = 2'd0,
    SND_REQUEST = 2'd1,
    SND_RELEASE = 2'd2
  } sendState_t;

  typedef enum logic {
    RCV_WAIT = 1'b0,
    RCV_HOLD = 1'b1
  } recvState_t;

  // strobes from the controllers to the datapath, one per domain
  typedef struct packed {
    logic sendLoad;     // sender domain: register the outgoing word
    logic recvCapture;  // receiver domain: capture the held word
  } hsStrobes_t;
endpackage

// File: rtl/xclk_hs_sync.sv
module xclk_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/xclk_hs_control.sv
module xclk_hs_control
  import xclk_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       sClk,
  input  logic       sRst,
  input  logic       startReq,
  output logic       busy,
  output logic       done,
  input  logic       rClk,
  input  logic       rRst,
  output logic       actionStrobe,
  output hsStrobes_t strobes
);
  sendState_t sendState;
  recvState_t recvState;
  logic cmdLine, ackLine;
  logic cmdSync, ackSync;

  // crossings: command into receiver, acknowledge into sender (R9)
  xclk_hs_sync #(.STAGES(SYNC_STAGES)) u_cmdSync (
    .clk(rClk), .rst(rRst), .din(cmdLine), .dout(cmdSync));
  xclk_hs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(sClk), .rst(sRst), .din(ackLine), .dout(ackSync));

  // ---------------- sender side ----------------
  assign strobes.sendLoad = (sendState == SND_IDLE) && startReq;
  assign busy = (sendState != SND_IDLE);

  always_ff @(posedge sClk) begin
    if (sRst) begin
      sendState <= SND_IDLE;
      cmdLine   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (sendState)
        SND_IDLE: if (startReq) begin
          sendState <= SND_REQUEST;
          cmdLine   <= 1'b1;
        end
        SND_REQUEST: if (ackSync) begin
          sendState <= SND_RELEASE;
          cmdLine   <= 1'b0;
        end
        SND_RELEASE: if (!ackSync) begin
          sendState <= SND_IDLE;
          done      <= 1'b1;
        end
        default: sendState <= SND_IDLE;
      endcase
    end
  end

  p_cmd_hold_r6: assert property (@(posedge sClk) disable iff (sRst)
    (cmdLine && !ackSync) |=> cmdLine);
  p_done_pulse_r7: assert property (@(posedge sClk) disable iff (sRst)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge sClk) disable iff (sRst)
    done |-> !busy);

  // ---------------- receiver side ----------------
  assign strobes.recvCapture = (recvState == RCV_WAIT) && cmdSync;

  always_ff @(posedge rClk) begin
    if (rRst) begin
      recvState    <= RCV_WAIT;
      ackLine      <= 1'b0;
      actionStrobe <= 1'b0;
    end else begin
      actionStrobe <= 1'b0;
      unique case (recvState)
        RCV_WAIT: if (cmdSync) begin
          recvState    <= RCV_HOLD;
          ackLine      <= 1'b1;
          actionStrobe <= 1'b1;
        end
        RCV_HOLD: if (!cmdSync) begin
          recvState <= RCV_WAIT;
          ackLine   <= 1'b0;
        end
        default: recvState <= RCV_WAIT;
      endcase
    end
  end

  p_ack_hold_r6: assert property (@(posedge rClk) disable iff (rRst)
    (ackLine && cmdSync) |=> ackLine);
  p_strobe_single_r5: assert property (@(posedge rClk) disable iff (rRst)
    actionStrobe |=> !actionStrobe);
  p_strobe_acked_r5: assert property (@(posedge rClk) disable iff (rRst)
    actionStrobe |-> ackLine);
endmodule

// File: rtl/xclk_hs_datapath.sv
module xclk_hs_datapath
  import xclk_hs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              sClk,
  input  logic              sRst,
  input  logic              rClk,
  input  logic              rRst,
  input  hsStrobes_t        strobes,
  input  logic [DATA_W-1:0] startData,
  output logic [DATA_W-1:0] heldData,
  output logic [DATA_W-1:0] actionData
);
  // sender-domain hold register, stable for the whole exchange (R4)
  always_ff @(posedge sClk) begin
    if (sRst)                  heldData <= '0;
    else if (strobes.sendLoad) heldData <= startData;
  end

  // receiver-domain capture, taken only while the held word is quiet
  always_ff @(posedge rClk) begin
    if (rRst)                     actionData <= '0;
    else if (strobes.recvCapture) actionData <= heldData;
  end
endmodule

// File: rtl/xclk_handshake.sv
module xclk_handshake
  import xclk_hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sClk,
  input  logic              sRst,
  input  logic              startReq,
  input  logic [DATA_W-1:0] startData,
  output logic              busy,
  output logic              done,
  input  logic              rClk,
  input  logic              rRst,
  output logic              actionStrobe,
  output logic [DATA_W-1:0] actionData
);
  hsStrobes_t        strobes;
  logic [DATA_W-1:0] heldData;

  xclk_hs_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sClk(sClk), .sRst(sRst), .startReq(startReq),
    .busy(busy), .done(done),
    .rClk(rClk), .rRst(rRst), .actionStrobe(actionStrobe),
    .strobes(strobes));

  xclk_hs_datapath #(.DATA_W(DATA_W)) u_dp (
    .sClk(sClk), .sRst(sRst), .rClk(rClk), .rRst(rRst),
    .strobes(strobes), .startData(startData),
    .heldData(heldData), .actionData(actionData));

  // held word frozen while a transfer is in flight, starts ignored (R3, R4)
  p_held_stable_r4: assert property (@(posedge sClk) disable iff (sRst)
    (busy && $past(busy)) |-> $stable(heldData));
endmodule

// File: tb/sim_xclk_handshake.sv
`timescale 1ns/100ps
module sim_xclk_handshake;
  localparam int W = 16;

  logic sClk = 1'b0, rClk = 1'b0;
  logic sRst, rRst, startReq;
  logic [W-1:0] startData;
  logic busy, done, actionStrobe;
  logic [W-1:0] actionData;

  real rHalf = 3.5;
  int  checks = 0, fails = 0;
  int  rEdges = 0, strobeCnt = 0, strobeEdge = 0;
  logic [W-1:0] strobeData;
  bit  finished = 0;

  xclk_handshake #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
    .sClk(sClk), .sRst(sRst), .startReq(startReq), .startData(startData),
    .busy(busy), .done(done), .rClk(rClk), .rRst(rRst),
    .actionStrobe(actionStrobe), .actionData(actionData));

  always #2.5 sClk = ~sClk;                 // 200 MHz sender clock
  initial begin #0.7; forever #(rHalf) rClk = ~rClk; end

  always @(posedge rClk) rEdges++;
  always @(negedge rClk) if (actionStrobe) begin
    strobeCnt++; strobeEdge = rEdges; strobeData = actionData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    sRst = 1; rRst = 1; startReq = 0; startData = '0;
    repeat (40) @(negedge sClk);
    sRst = 0; rRst = 0;
    @(negedge sClk);
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(actionStrobe == 0, "R1 actionStrobe", actionStrobe, 0);
  endtask

  // one transfer; optionally fire a second start while busy (R3)
  task automatic runXfer(input logic [W-1:0] word, input bit poke, input string tag);
    int n, startR, cnt0;
    cnt0 = strobeCnt;
    @(negedge sClk); startReq = 1; startData = word;
    @(posedge sClk); startR = rEdges;
    @(negedge sClk); startReq = 0; startData = ~word;
    check(busy == 1, {"R2 busy after accept ", tag}, busy, 1);
    n = 0;
    while (!done && n < 2000) begin
      if (poke && n == 1) begin startReq = 1; startData = word ^ 16'h5a5a; end
      else startReq = 0;
      @(negedge sClk); n++;
    end
    startReq = 0;
    check(done == 1, {"R7 done seen ", tag}, done, 1);
    check(busy == 0, {"R7 busy falls with done ", tag}, busy, 0);
    check(n >= 4, {"R8 R9 sender latency ", tag}, n, 4);
    @(negedge sClk);
    check(done == 0, {"R7 done single cycle ", tag}, done, 0);
    repeat (30) @(negedge sClk);
    check(busy == 0, {"R3 no restart ", tag}, busy, 0);
    check(strobeCnt - cnt0 == 1, {"R5 R6 one action ", tag}, strobeCnt - cnt0, 1);
    check(strobeData == word, {"R4 action data ", tag}, strobeData, word);
    check(strobeEdge - startR >= 3, {"R8 R9 receiver latency ", tag},
          strobeEdge - startR, 3);
  endtask

  initial begin
    doReset();
    rHalf = 3.5;  runXfer(16'h1234, 0, "similar clocks");
    runXfer(16'hbeef, 0, "back to back");
    rHalf = 1.5;  runXfer(16'h00ff, 0, "fast receiver");
    runXfer(16'hc3c3, 1, "fast receiver start while busy");
    rHalf = 18.5; runXfer(16'ha5a5, 0, "slow receiver");
    runXfer(16'h0f0f, 1, "slow receiver start while busy");
    doReset();
    check(actionData == 0, "R1 actionData cleared", actionData, 0);
    rHalf = 3.5;  runXfer(16'hffff, 0, "after reset");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule